// File: doc/BRIEF.md
# Winner-Take-All Victim Transform with Training-Target Select

This block sits behind a per-set classifier in a learned cache replacement scheme. Each cycle it may accept one response value per way of the set. The way with the smallest response is the weakest match to the incoming tag, so it becomes the replacement candidate. The block turns the response vector into a saturated bipolar vector. The candidate way is driven to full-scale high and every other way to full-scale low. The block also reports the candidate's index.

The same cycle also produces a per-way error vector that feeds the classifier's weight update. A lookup miss uses the saturated vector as the training target. A hit, or a fill into an empty line, uses a one-hot bipolar target that marks the hit way or the insertion way given by the controller. In both cases the error is the target minus the response. All outputs are registered, appear one cycle after the input is accepted, and are qualified by a valid flag.

Top module: `wta_victim_select`

## Requirements
- R1: While `rst` is high and after it falls, until the first accepted input, `out_valid` is 0 and `victim`, `xform` and `err` are all zero.
- R2: `out_valid` is 1 exactly one cycle after a cycle with `in_valid` high. It is 0 otherwise. `victim`, `xform` and `err` keep their values through cycles without an accepted input.
- R3: Responses and transform elements are signed 8-bit two's complement values with 6 fraction bits. Way w occupies bits [8w+7:8w]. The way holding the smallest response is set to +1.0 (code 64, 0x40), and every other way is set to −1.0 (code −64, 0xC0).
- R4: When several ways share the smallest response, only the lowest-numbered of them is set to +1.0.
- R5: `victim` equals the index of the way that `xform` sets to +1.0.
- R6: On a miss (`hit` and `empty` both 0), error element w equals xform[w] − resp[w], as a signed 9-bit value in bits [9w+8:9w] of `err`.
- R7: On a hit, the target is +1.0 at way `tgt_way` and −1.0 elsewhere. Error element w equals target[w] − resp[w].
- R8: `empty` alone selects the same control-supplied target as `hit`. `xform` and `victim` are unaffected by `hit`, `empty` and `tgt_way`.
- R9: Error elements are exact at the range extremes (for example +64 − (−128) = 192 and −64 − 127 = −191), with no wraparound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Response vector and control flags are valid this cycle |
| resp | input | 32 | Per-way signed responses, 8 bits per way |
| hit | input | 1 | Lookup hit; train toward the hit way |
| empty | input | 1 | Fill into an empty line; train toward the insertion way |
| tgt_way | input | 2 | Hit way or insertion way |
| out_valid | output | 1 | Outputs below are fresh this cycle |
| victim | output | 2 | Way to replace |
| xform | output | 32 | Saturated bipolar vector, 8 bits per way |
| err | output | 36 | Per-way training error, 9 bits per way |

## Verification
A corrupted minimum search or tie rule shows up as a wrong `victim` and a +1.0 in the wrong lane of `xform`. It is visible in the cycle that follows the accepted input. A wrong target select or a narrowed subtraction shows up only in `err`, and only for hit/empty inputs or for responses near the range extremes. The directed cases are chosen so that each of these paths is exercised, and every lane is compared against values computed independently in the bench. A stuck or leaking valid register appears as `out_valid` set in an idle cycle, or as outputs changing without an accepted input.

// File: rtl/wta_pkg.sv
package wta_pkg;
  // Selector for the training target.
  typedef enum logic {
    TGT_XFORM = 1'b0,
    TGT_CTRL  = 1'b1
  } tgt_sel_e;
endpackage

// File: rtl/wta_argmin.sv
// Lowest-index minimum search over WAYS signed lanes.
module wta_argmin #(
  parameter int WAYS = 4,
  parameter int DW   = 8,
  localparam int IW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS*DW-1:0] resp,
  output logic [IW-1:0]      idx
);
  logic signed [DW-1:0] best;

  always_comb begin
    best = $signed(resp[DW-1:0]);
    idx  = '0;
    for (int i = 1; i < WAYS; i++) begin
      // Strict compare keeps the earlier lane on equal values.
      if ($signed(resp[i*DW +: DW]) < best) begin
        best = $signed(resp[i*DW +: DW]);
        idx  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wta_bipolar.sv
// Expands a way index into a saturated bipolar vector.
module wta_bipolar #(
  parameter int WAYS = 4,
  parameter int DW   = 8,
  parameter int FRAC = 6,
  localparam int IW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [IW-1:0]      hot,
  output logic [WAYS*DW-1:0] vec
);
  localparam logic signed [DW-1:0] LVL_HI = DW'(1 << FRAC);
  localparam logic signed [DW-1:0] LVL_LO = -LVL_HI;

  for (genvar g = 0; g < WAYS; g++) begin : g_lane
    assign vec[g*DW +: DW] = (hot == IW'(g)) ? LVL_HI : LVL_LO;
  end
endmodule

// File: rtl/wta_error.sv
// Per-lane target minus response, one bit wider than the inputs.
module wta_error #(
  parameter int WAYS = 4,
  parameter int DW   = 8
) (
  input  logic [WAYS*DW-1:0]     tgt,
  input  logic [WAYS*DW-1:0]     resp,
  output logic [WAYS*(DW+1)-1:0] err
);
  for (genvar g = 0; g < WAYS; g++) begin : g_lane
    logic signed [DW:0] t_ext;
    logic signed [DW:0] r_ext;
    assign t_ext = {tgt[g*DW+DW-1],  tgt[g*DW +: DW]};
    assign r_ext = {resp[g*DW+DW-1], resp[g*DW +: DW]};
    assign err[g*(DW+1) +: DW+1] = t_ext - r_ext;
  end
endmodule

// File: rtl/wta_victim_select.sv
module wta_victim_select
  import wta_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int DW   = 8,
  parameter int FRAC = 6,
  localparam int IW  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int EW  = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [WAYS*DW-1:0]   resp,
  input  logic                 hit,
  input  logic                 empty,
  input  logic [IW-1:0]        tgt_way,
  output logic                 out_valid,
  output logic [IW-1:0]        victim,
  output logic [WAYS*DW-1:0]   xform,
  output logic [WAYS*EW-1:0]   err
);
  localparam logic signed [DW-1:0] LVL_HI = DW'(1 << FRAC);
  localparam logic signed [DW-1:0] LVL_LO = -LVL_HI;

  logic [IW-1:0]      min_idx;
  logic [WAYS*DW-1:0] xf_vec;
  logic [WAYS*DW-1:0] ctl_vec;
  logic [WAYS*DW-1:0] tgt_vec;
  logic [WAYS*EW-1:0] err_vec;
  tgt_sel_e           tsel;

  wta_argmin #(.WAYS(WAYS), .DW(DW)) u_min (
    .resp (resp),
    .idx  (min_idx)
  );

  wta_bipolar #(.WAYS(WAYS), .DW(DW), .FRAC(FRAC)) u_xf (
    .hot (min_idx),
    .vec (xf_vec)
  );

  wta_bipolar #(.WAYS(WAYS), .DW(DW), .FRAC(FRAC)) u_ctl (
    .hot (tgt_way),
    .vec (ctl_vec)
  );

  assign tsel    = (hit || empty) ? TGT_CTRL : TGT_XFORM;
  assign tgt_vec = (tsel == TGT_CTRL) ? ctl_vec : xf_vec;

  wta_error #(.WAYS(WAYS), .DW(DW)) u_err (
    .tgt  (tgt_vec),
    .resp (resp),
    .err  (err_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      victim    <= '0;
      xform     <= '0;
      err       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        victim <= min_idx;
        xform  <= xf_vec;
        err    <= err_vec;
      end
    end
  end

  // Valid timing.
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(victim) && $stable(xform) && $stable(err))); // R2

  // Victim lane is the single high lane.
  AST_ONE_HIGH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(xform[victim*DW +: DW]) == LVL_HI)); // R5

  for (genvar g = 0; g < WAYS; g++) begin : g_chk
    // The selected lane is no larger than any other lane; ties go low.
    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ($signed(resp[g*DW +: DW]) >= $signed(resp[min_idx*DW +: DW]))); // R3
    AST_TIE_LOW: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (resp[g*DW +: DW] == resp[min_idx*DW +: DW])) |-> (IW'(g) >= min_idx)); // R4
    // Bipolar lanes only.
    AST_LANE_LEVEL: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (($signed(xform[g*DW +: DW]) == LVL_HI) ==
                     (victim == IW'(g)))); // R3
    // Error plus registered response recovers the chosen target lane.
    AST_ERR_MISS: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !$past(hit) && !$past(empty)) |->
        ($signed(err[g*EW +: EW]) + $signed({$past(resp[g*DW+DW-1]), $past(resp[g*DW +: DW])})
         == $signed({xform[g*DW+DW-1], xform[g*DW +: DW]}))); // R6
    AST_ERR_CTRL: assert property (@(posedge clk) disable iff (rst)
      (out_valid && ($past(hit) || $past(empty))) |->
        ($signed(err[g*EW +: EW]) + $signed({$past(resp[g*DW+DW-1]), $past(resp[g*DW +: DW])})
         == (($past(tgt_way) == IW'(g)) ? EW'(LVL_HI) : EW'(LVL_LO)))); // R7
  end
endmodule

// File: tb/wta_victim_select_test.sv
module wta_victim_select_test;
  localparam int WAYS = 4;
  localparam int DW   = 8;
  localparam int EW   = 9;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic [WAYS*DW-1:0] resp;
  logic              hit;
  logic              empty;
  logic [1:0]        tgt_way;
  logic              out_valid;
  logic [1:0]        victim;
  logic [WAYS*DW-1:0] xform;
  logic [WAYS*EW-1:0] err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wta_victim_select uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .resp(resp),
    .hit(hit), .empty(empty), .tgt_way(tgt_way),
    .out_valid(out_valid), .victim(victim), .xform(xform), .err(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int xf_lane(input int w);
    return $signed(xform[w*DW +: DW]);
  endfunction

  function automatic int err_lane(input int w);
    return $signed(err[w*EW +: EW]);
  endfunction

  // Drive one vector, then check every lane against the bench model.
  task automatic run_vec(input string req, input int r0, input int r1, input int r2,
                         input int r3, input bit h, input bit e, input int tw);
    int r[4];
    int mi;
    int tgt;
    r[0] = r0; r[1] = r1; r[2] = r2; r[3] = r3;
    mi = 0;
    for (int w = 1; w < WAYS; w++) if (r[w] < r[mi]) mi = w;
    @(negedge clk);
    for (int w = 0; w < WAYS; w++) resp[w*DW +: DW] = DW'(r[w]);
    hit = h; empty = e; tgt_way = 2'(tw); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " victim"}, int'(victim), mi);
    for (int w = 0; w < WAYS; w++) begin
      chk({req, " xform"}, xf_lane(w), (w == mi) ? 64 : -64);
      if (h || e) tgt = (w == tw) ? 64 : -64;
      else        tgt = (w == mi) ? 64 : -64;
      chk({req, " err"}, err_lane(w), tgt - r[w]);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; resp = '0; hit = 1'b0; empty = 1'b0; tgt_way = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 victim", int'(victim), 0);
    chk("R1 xform", int'(xform != '0), 0);
    chk("R1 err", int'(err != '0), 0);
  endtask

  task automatic t_example();
    // 0.1, 0.9, 0.8, 0.3 in Q1.6
    run_vec("R3 R6 example", 6, 58, 51, 19, 0, 0, 0);
    run_vec("R3 R5 min last", 40, 12, 30, -5, 0, 0, 0);
  endtask

  task automatic t_ties();
    run_vec("R4 tie mid", 20, -7, 3, -7, 0, 0, 0);
    run_vec("R4 all equal", 9, 9, 9, 9, 0, 0, 0);
  endtask

  task automatic t_ctrl_target();
    run_vec("R7 hit", 10, -20, 30, 40, 1, 0, 2);
    run_vec("R8 empty", 5, 6, -1, 7, 0, 1, 3);
    run_vec("R7 R8 both", 1, 2, 3, 4, 1, 1, 0);
  endtask

  task automatic t_extremes();
    run_vec("R9 low miss", -128, 127, 127, 127, 0, 0, 0);
    run_vec("R9 hit swing", -128, 127, 0, 64, 1, 0, 1);
  endtask

  task automatic t_hold();
    logic [1:0]          v0;
    logic [WAYS*DW-1:0]  x0;
    logic [WAYS*EW-1:0]  e0;
    run_vec("R2 load", 50, 60, -30, 10, 0, 0, 0);
    v0 = victim; x0 = xform; e0 = err;
    resp = '1; hit = 1'b1; tgt_way = 2'd1;
    repeat (2) @(negedge clk);
    chk("R2 idle valid", int'(out_valid), 0);
    chk("R2 hold victim", int'(victim), int'(v0));
    chk("R2 hold xform", int'(xform == x0), 1);
    chk("R2 hold err", int'(err == e0), 1);
  endtask

  initial begin
    t_reset();
    t_example();
    t_ties();
    t_ctrl_target();
    t_extremes();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule